// File: doc/BRIEF.md
# Watchdog Supervisor with Delayed CPU Reset

This block counts a prescaled clock without stopping and raises an interval flag each time a programmed number of prescaled ticks has gone by. Software can use it as a plain periodic time base, as a source of interval interrupts, or as a supervisor that pulls the CPU into reset when it stops checking in. The prescaler divides the input clock by 1, 16 or 256. A two-bit interval select then picks one of four power-of-two tap points on a single long counter.

When the interval ends, the flag is set at once. If the reset function is armed, a reset pulse follows a fixed grace period later, unless software restarts the counter first or disarms the reset. The reset function and the interrupt function are separate, so either can be used alone. A cause flag records that the watchdog produced the reset. It lives in the power-on domain (`rst_n`), which the watchdog's own reset pulse does not clear. `rst_n` is taken as already synchronised to `clk` upstream.

Control inputs look like register bits, with write strobes for the self-clearing restart bit and the two flag clears. Bus decoding lives outside this block.

Top module: `wdog_supervisor`

## Requirements
- R1: After `rst_n` is released, `irq_flag_o`, `irq_o`, `cpu_rst_o`, `cause_o` and `restart_o` are all 0.
- R2: With a divide-by-1 prescale, the flag is set at rising edge N after reset release, where N is 2^(TAP_BASE), 2^(TAP_BASE+TAP_STEP), 2^(TAP_BASE+2·TAP_STEP) and 2^(TAP_BASE+3·TAP_STEP) for `intv_sel_i` = 00, 01, 10 and 11. The defaults give 2^17, 2^20, 2^23 and 2^26.
- R3: `presc_sel_i` = 0X divides the clock by 1, 10 divides by 16, and 11 divides by 256. The interval in clocks is the divisor times the tick count from R2.
- R4: A one-cycle `restart_i` strobe makes `restart_o` read 1 for exactly one cycle after the capturing edge, with no further action by software. It also zeroes the counter on the following edge, so the next flag comes N+1 edges after the capturing edge.
- R5: `irq_flag_o` stays set until a `flag_clr_i` strobe clears it on the next edge. A timeout in the same cycle wins over the clear.
- R6: The counter keeps running through each timeout. After a clear, the flag sets again 2N edges after reset release.
- R7: `irq_o` is 1 exactly when the flag, `irq_en_i` and `gie_i` are all 1.
- R8: With `rst_en_i` set, a timeout at edge T drives `cpu_rst_o` high for exactly one cycle, starting at edge T+GRACE_CLKS (default 512).
- R9: A restart captured during the grace period cancels the pending reset.
- R10: Clearing `rst_en_i` during the grace period cancels the pending reset.
- R11: `cause_o` is set on the edge after the reset pulse. It then holds until a `cause_clr_i` strobe or `rst_n`.
- R12: With `rst_en_i` low, a timeout never produces `cpu_rst_o`, yet it still sets the flag. With the interrupt disabled, the reset still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| restart_i | input | 1 | Write strobe for the restart bit |
| rst_en_i | input | 1 | Arms the delayed CPU reset |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| flag_clr_i | input | 1 | Strobe that clears the interval flag |
| cause_clr_i | input | 1 | Strobe that clears the reset-cause flag |
| presc_sel_i | input | 2 | Prescaler divisor select |
| intv_sel_i | input | 2 | Interval tap select |
| restart_o | output | 1 | Restart bit readback, self-clearing |
| irq_flag_o | output | 1 | Interval flag |
| irq_o | output | 1 | Gated interrupt request |
| cpu_rst_o | output | 1 | One-cycle CPU reset pulse |
| cause_o | output | 1 | Sticky watchdog reset cause |

## Verification
The bench targets the exact timeout edge for every tap and every divisor. A design with an off-by-one tap or prescaler would set the flag one tick early or late, and would fail on the edge before or the edge after. It also restarts the counter at random points and checks the flag shifts by the right number of edges, which catches a restart that is lost or that leaves the prescaler phase behind. Inside the grace period, the bench restarts the counter or disarms the reset and checks that no pulse appears, which catches a reset that was committed too early. It also checks that the pulse lasts one cycle and that the cause flag survives the pulse until software clears it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_NTAP = 4;
  localparam int unsigned WD_SELW = 2;

  typedef enum logic [1:0] {
    PS_BYPASS0 = 2'b00,
    PS_BYPASS1 = 2'b01,
    PS_MID     = 2'b10,
    PS_HIGH    = 2'b11
  } presc_sel_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned MID_LOG = 4,
  parameter int unsigned HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  import wdog_pkg::*;

  logic [HI_LOG-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = clr_i ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // Tick on the last count of the selected divide window.
  always_comb begin
    case (presc_sel_e'(sel_i))
      PS_MID:  tick_o = &pc_q[MID_LOG-1:0];
      PS_HIGH: tick_o = &pc_q;
      default: tick_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned TAP_BASE = 17,
  parameter int unsigned TAP_STEP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       timeout_o
);
  import wdog_pkg::*;

  localparam int unsigned CW = TAP_BASE + (WD_NTAP - 1) * TAP_STEP;

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [WD_NTAP-1:0] hit;

  // One all-ones detector per tap: tap i spans TAP_BASE + i*TAP_STEP bits.
  for (genvar i = 0; i < WD_NTAP; i++) begin : g_tap
    assign hit[i] = &cnt_q[TAP_BASE + i*TAP_STEP - 1 : 0];
  end

  assign timeout_o = tick_i & hit[sel_i] & ~clr_i;

  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_grace.sv
module wdog_grace #(
  parameter int unsigned GRACE_CLKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_i,
  input  logic arm_i,
  input  logic cancel_i,
  output logic fire_o
);
  localparam int unsigned GW = (GRACE_CLKS > 2) ? $clog2(GRACE_CLKS) : 1;
  localparam logic [GW-1:0] LAST = GW'(GRACE_CLKS - 1);

  logic          pend_q, pend_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          fire_q, fire_d;

  always_comb begin
    fire_d = pend_q & arm_i & ~cancel_i & (gcnt_q == LAST);
    if (!arm_i || cancel_i || fire_d) pend_d = 1'b0;
    else if (timeout_i)               pend_d = 1'b1;
    else                              pend_d = pend_q;
    gcnt_d = (pend_q && pend_d) ? gcnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      gcnt_q <= '0;
      fire_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      gcnt_q <= gcnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned TAP_BASE    = 17,
  parameter int unsigned TAP_STEP    = 3,
  parameter int unsigned GRACE_CLKS  = 512,
  parameter int unsigned PRE_MID_LOG = 4,
  parameter int unsigned PRE_HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       rst_en_i,
  input  logic       irq_en_i,
  input  logic       gie_i,
  input  logic       flag_clr_i,
  input  logic       cause_clr_i,
  input  logic [1:0] presc_sel_i,
  input  logic [1:0] intv_sel_i,
  output logic       restart_o,
  output logic       irq_flag_o,
  output logic       irq_o,
  output logic       cpu_rst_o,
  output logic       cause_o
);
  logic restart_q, restart_d;
  logic flag_q, flag_d;
  logic cause_q, cause_d;
  logic tick, timeout, cnt_clr, fire;

  // Counter and prescaler restart on a restart bit or on the reset pulse.
  assign cnt_clr = restart_q | fire;

  wdog_prescale #(.MID_LOG(PRE_MID_LOG), .HI_LOG(PRE_HI_LOG)) i_presc (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .sel_i(presc_sel_i), .tick_o(tick)
  );

  wdog_count #(.TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) i_count (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .tick_i(tick),
    .sel_i(intv_sel_i), .timeout_o(timeout)
  );

  wdog_grace #(.GRACE_CLKS(GRACE_CLKS)) i_grace (
    .clk(clk), .rst_n(rst_n), .timeout_i(timeout), .arm_i(rst_en_i),
    .cancel_i(restart_q), .fire_o(fire)
  );

  always_comb begin
    restart_d = restart_i;
    if (timeout)         flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    else                 flag_d = flag_q;
    if (fire)             cause_d = 1'b1;
    else if (cause_clr_i) cause_d = 1'b0;
    else                  cause_d = cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      flag_q    <= 1'b0;
      cause_q   <= 1'b0;
    end else begin
      restart_q <= restart_d;
      flag_q    <= flag_d;
      cause_q   <= cause_d;
    end
  end

  assign restart_o  = restart_q;
  assign irq_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i & gie_i;
  assign cpu_rst_o  = fire;
  assign cause_o    = cause_q;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic restart_i,
  input logic rst_en_i,
  input logic flag_clr_i,
  input logic cause_clr_i,
  input logic restart_o,
  input logic irq_flag_o,
  input logic cpu_rst_o,
  input logic cause_o
);
  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |=> !cpu_rst_o);
  // R4
  restart_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && !restart_i) |=> !restart_o);
  // R11
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |=> cause_o);
  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o && !cause_clr_i) |=> cause_o);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o);
  // R9
  cancel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !cpu_rst_o);
  // R10
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en_i |=> !cpu_rst_o);
endmodule

bind wdog_supervisor wdog_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .rst_en_i(rst_en_i),
  .flag_clr_i(flag_clr_i), .cause_clr_i(cause_clr_i), .restart_o(restart_o),
  .irq_flag_o(irq_flag_o), .cpu_rst_o(cpu_rst_o), .cause_o(cause_o)
);

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int TB_BASE = 4;
  localparam int TB_STEP = 1;
  localparam int TB_GRACE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_i = 1'b0, rst_en_i = 1'b0, irq_en_i = 1'b0, gie_i = 1'b0;
  logic flag_clr_i = 1'b0, cause_clr_i = 1'b0;
  logic [1:0] presc_sel_i = 2'b00, intv_sel_i = 2'b00;
  logic restart_o, irq_flag_o, irq_o, cpu_rst_o, cause_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_supervisor #(.TAP_BASE(TB_BASE), .TAP_STEP(TB_STEP), .GRACE_CLKS(TB_GRACE),
                    .PRE_MID_LOG(4), .PRE_HI_LOG(8)) i_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .rst_en_i(rst_en_i),
    .irq_en_i(irq_en_i), .gie_i(gie_i), .flag_clr_i(flag_clr_i),
    .cause_clr_i(cause_clr_i), .presc_sel_i(presc_sel_i), .intv_sel_i(intv_sel_i),
    .restart_o(restart_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o),
    .cpu_rst_o(cpu_rst_o), .cause_o(cause_o)
  );

  function automatic int divisor(logic [1:0] ps);
    if (ps == 2'b10) return 16;
    if (ps == 2'b11) return 256;
    return 1;
  endfunction

  function automatic int interval(logic [1:0] ps, logic [1:0] is);
    return divisor(ps) * (1 << (TB_BASE + int'(is) * TB_STEP));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    restart_i = 1'b0; flag_clr_i = 1'b0; cause_clr_i = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int seen;
    void'($urandom(32'd4242));

    // R1 reset state
    reset_dut();
    chk("R1 flag", irq_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 cpu_rst", cpu_rst_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 restart", restart_o, 0);

    // R2 every tap at divide-by-1
    for (int s = 0; s < 4; s++) begin
      presc_sel_i = 2'b00; intv_sel_i = 2'(s);
      n = interval(presc_sel_i, intv_sel_i);
      reset_dut();
      step(n - 1); chk("R2 before tap", irq_flag_o, 0);
      step(1);     chk("R2 at tap", irq_flag_o, 1);
    end

    // R3 prescaler variants
    for (int p = 1; p < 4; p++) begin
      presc_sel_i = 2'(p); intv_sel_i = 2'b00;
      n = interval(presc_sel_i, intv_sel_i);
      reset_dut();
      step(n - 1); chk("R3 before tap", irq_flag_o, 0);
      step(1);     chk("R3 at tap", irq_flag_o, 1);
    end

    // R7 interrupt gating (flag currently set)
    for (int c = 0; c < 4; c++) begin
      irq_en_i = c[0]; gie_i = c[1];
      #1;
      chk("R7 gating", irq_o, (c == 3) ? 1 : 0);
    end
    irq_en_i = 1'b0; gie_i = 1'b0;

    // R5, R6 clear and free running
    presc_sel_i = 2'b00; intv_sel_i = 2'b00;
    n = interval(2'b00, 2'b00);
    reset_dut();
    step(n); chk("R6 first", irq_flag_o, 1);
    flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
    chk("R5 cleared", irq_flag_o, 0);
    step(n - 2); chk("R6 before second", irq_flag_o, 0);
    step(1);     chk("R6 second", irq_flag_o, 1);

    // R4 restart
    reset_dut();
    step(5);
    restart_i = 1'b1; step(1); restart_i = 1'b0;
    chk("R4 readback", restart_o, 1);
    step(1); chk("R4 self clear", restart_o, 0);
    step(n - 1); chk("R4 before", irq_flag_o, 0);
    step(1);     chk("R4 after", irq_flag_o, 1);

    // R8, R11, R12 delayed reset with interrupt disabled
    rst_en_i = 1'b1;
    reset_dut();
    step(n);
    chk("R12 flag", irq_flag_o, 1);
    chk("R12 no irq", irq_o, 0);
    step(TB_GRACE - 1); chk("R8 before", cpu_rst_o, 0);
    step(1); chk("R8 pulse", cpu_rst_o, 1);
    step(1); chk("R8 width", cpu_rst_o, 0);
    chk("R11 set", cause_o, 1);
    rst_en_i = 1'b0;
    step(10); chk("R11 hold", cause_o, 1);
    cause_clr_i = 1'b1; step(1); cause_clr_i = 1'b0;
    chk("R11 clear", cause_o, 0);

    // R9 restart in grace
    rst_en_i = 1'b1;
    reset_dut();
    step(n + 3);
    restart_i = 1'b1; step(1); restart_i = 1'b0;
    seen = 0;
    for (int k = 0; k < TB_GRACE + 4; k++) begin
      step(1); if (cpu_rst_o) seen = 1;
    end
    chk("R9 cancelled", seen, 0);

    // R10 disarm in grace, R12 flag unaffected
    reset_dut();
    step(n + 2);
    rst_en_i = 1'b0;
    seen = 0;
    for (int k = 0; k < TB_GRACE + 4; k++) begin
      step(1); if (cpu_rst_o) seen = 1;
    end
    chk("R10 disarmed", seen, 0);
    chk("R12 flag kept", irq_flag_o, 1);

    // R2/R3/R4 random intervals and restart points
    for (int it = 0; it < 10; it++) begin
      int r;
      presc_sel_i = 2'($urandom % 4);
      if (presc_sel_i == 2'b11)      intv_sel_i = 2'b00;
      else if (presc_sel_i == 2'b10) intv_sel_i = 2'($urandom % 3);
      else                           intv_sel_i = 2'($urandom % 4);
      n = interval(presc_sel_i, intv_sel_i);
      reset_dut();
      if ($urandom % 2 == 1) begin
        r = 2 + int'($urandom % 32'(n - 4));
        step(r - 1);
        restart_i = 1'b1; step(1); restart_i = 1'b0;
        step(n); chk("R4 rand before", irq_flag_o, 0);
        step(1); chk("R4 rand at", irq_flag_o, 1);
      end else begin
        step(n - 1); chk("R3 rand before", irq_flag_o, 0);
        step(1);     chk("R3 rand at", irq_flag_o, 1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule